// File: doc/BRIEF.md
# Lockstep Result Checker and Commit Gate

This block sits behind a pair of identical execution units that run the same instruction in lockstep. It decides whether each result may leave the core. Each instruction moves through four one-cycle stages on a single clock. First the unit A result is written into an internal checkpoint register that software cannot reach. Next a SEC-DED check code is computed from that checkpointed value. Then both unit outputs are tested against the code. Finally the result is released with a one-cycle commit pulse, which marks it as ready to forward to the second-level cache.

The stages are pipelined, so a new instruction may enter on every cycle. Every stage has a fault input. A fault raised while an instruction occupies a stage attaches to that instruction only, and blocks its commit. A disagreement in the check stage drops the instruction and sets a sticky error flag. Only reset clears that flag.

Top module: `lockstep_commit_gate`

## Requirements
- R1: While the active-high synchronous reset is held, `cp_we`, `cm_vld` and `err_flag` are low from the first clock edge on, and every stage is empty.
- R2: When `in_vld` is high at a clock edge, `cp_we` is high for the next cycle and `cp_data` equals the `in_res_a` value that was sampled. When `in_vld` is low, `cp_we` is low in the next cycle.
- R3: Take an instruction with equal unit results and no fault. `cm_vld` is high for exactly one cycle, three cycles after its `cp_we` cycle, and `cm_data` carries its result.
- R4: The check code has 8 bits. The 64 data bits 0..63 take codeword positions 1..71 in ascending order, skipping the powers of two. Check bit k (k = 0..6) is the XOR of the data bits whose position has bit k set. Check bit 7 is the XOR of all data bits and check bits 0..6. An instruction is dropped as mismatched exactly when the code of `in_res_b` differs from the code of the checkpointed `in_res_a`.
- R5: A mismatched instruction produces no commit. `err_flag` rises in the cycle where its commit would have appeared and stays high until reset. Later instructions keep committing.
- R6: A disagreement in 1, 2 or 3 bit positions between the two unit results is always detected as a mismatch.
- R7: A fault on `in_flt` with the instruction, on `pa_flt` during its checkpoint cycle, on `eg_flt` during its code cycle, or on `ck_flt` during its check cycle blocks that instruction's commit. A fault on its own does not set `err_flag`.
- R8: A fault input raised while its stage holds no instruction, or while it holds a different instruction, has no effect on any other instruction's commit.
- R9: Instructions presented on consecutive cycles are each checked and committed independently, one commit per cycle, in entry order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for all stages |
| rst | input | 1 | Active-high synchronous reset |
| in_vld | input | 1 | A new instruction result is presented |
| in_res_a | input | 64 | Result from execution unit A |
| in_res_b | input | 64 | Result from execution unit B |
| in_flt | input | 1 | Fault raised during execution of the entering instruction |
| pa_flt | input | 1 | Fault for the instruction in the checkpoint stage |
| eg_flt | input | 1 | Fault for the instruction in the code-generation stage |
| ck_flt | input | 1 | Fault for the instruction in the check stage |
| cp_we | output | 1 | Checkpoint register written this cycle |
| cp_data | output | 64 | Checkpoint register contents |
| cm_vld | output | 1 | Commit pulse: result released toward the cache |
| cm_data | output | 64 | Committed result |
| err_flag | output | 1 | Sticky lockstep disagreement flag |

## Verification
The bench first sends long back-to-back runs of matching results, which separates correct pipelining and ordering from stalls or skipped slots. A second phase adds random faults on all four fault inputs, including cycles where a stage is empty. This shows that each fault follows its own instruction and that a fault alone never raises the error flag. A third phase mixes in 1-, 2- and 3-bit disagreements and wide random disagreements, each predicted by an independent code computation. This separates the detection guarantee from the exact code definition. Directed cases place single- and double-bit flips between clean instructions to check the sticky flag and that commits continue after an error.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
  localparam int DATA_W = 64;
  localparam int POS_W  = $clog2(DATA_W + $clog2(DATA_W) + 1);
  localparam int CODE_W = POS_W + 1;

  typedef struct packed {
    logic              vld;
    logic              flt;
    logic [DATA_W-1:0] a;
    logic [DATA_W-1:0] b;
  } slot_t;

  // Hamming SEC-DED: data bits fill non-power-of-two positions in order,
  // check bit k covers positions with bit k set, top bit is overall parity.
  function automatic logic [CODE_W-1:0] ecc_gen(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p < (1 << POS_W); p++) begin
      if (((p & (p - 1)) != 0) && (j < DATA_W)) begin
        for (int k = 0; k < POS_W; k++) begin
          if (p[k]) c[k] = c[k] ^ d[j];
        end
        j++;
      end
    end
    c[CODE_W-1] = ^{d, c[POS_W-1:0]};
    return c;
  endfunction
endpackage

// File: rtl/lcg_ckpt_stage.sv
module lcg_ckpt_stage
  import lcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic              in_flt,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output slot_t             slot_q,
  output logic [DATA_W-1:0] ckpt_q
);
  always_ff @(posedge clk) begin
    if (rst) slot_q.vld <= 1'b0;
    else     slot_q.vld <= in_vld;
    slot_q.flt <= in_flt;
    slot_q.a   <= in_a;
    slot_q.b   <= in_b;
    if (in_vld) ckpt_q <= in_a;
  end

  // R2
  ckpt_write_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> slot_q.vld && (ckpt_q == $past(in_a)));
endmodule

// File: rtl/lcg_code_stage.sv
module lcg_code_stage
  import lcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  slot_t             slot_i,
  input  logic [DATA_W-1:0] ckpt_i,
  input  logic              stage_flt,
  output slot_t             slot_q,
  output logic [CODE_W-1:0] code_q
);
  logic fault_here;
  assign fault_here = slot_i.vld & stage_flt;

  always_ff @(posedge clk) begin
    if (rst) slot_q.vld <= 1'b0;
    else     slot_q.vld <= slot_i.vld;
    slot_q.flt <= slot_i.flt | fault_here;
    slot_q.a   <= slot_i.a;
    slot_q.b   <= slot_i.b;
    code_q     <= ecc_gen(ckpt_i);
  end

  // R7
  flt_carry_chk: assert property (@(posedge clk) disable iff (rst)
    slot_i.vld && stage_flt |=> slot_q.vld && slot_q.flt);
endmodule

// File: rtl/lcg_check_stage.sv
module lcg_check_stage
  import lcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  slot_t             slot_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              prev_flt,
  input  logic              here_flt,
  output logic              ck_vld,
  output logic              ck_mis,
  output logic              ck_flt_any,
  output logic [DATA_W-1:0] ck_data
);
  localparam int UNITS = 2;

  slot_t             slot_q;
  logic [CODE_W-1:0] code_q;
  logic [DATA_W-1:0] unit_res [UNITS];
  logic [UNITS-1:0]  unit_mis;

  always_ff @(posedge clk) begin
    if (rst) slot_q.vld <= 1'b0;
    else     slot_q.vld <= slot_i.vld;
    slot_q.flt <= slot_i.flt | (slot_i.vld & prev_flt);
    slot_q.a   <= slot_i.a;
    slot_q.b   <= slot_i.b;
    code_q     <= code_i;
  end

  assign unit_res[0] = slot_q.a;
  assign unit_res[1] = slot_q.b;

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    assign unit_mis[u] = (ecc_gen(unit_res[u]) != code_q);
  end

  assign ck_vld     = slot_q.vld;
  assign ck_mis     = |unit_mis;
  assign ck_flt_any = slot_q.flt | here_flt;
  assign ck_data    = slot_q.a;

  // R6
  small_diff_chk: assert property (@(posedge clk) disable iff (rst)
    slot_q.vld && ($countones(slot_q.a ^ slot_q.b) >= 1) &&
    ($countones(slot_q.a ^ slot_q.b) <= 3) |-> ck_mis);
endmodule

// File: rtl/lcg_commit_stage.sv
module lcg_commit_stage
  import lcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ck_vld,
  input  logic              ck_mis,
  input  logic              ck_flt,
  input  logic [DATA_W-1:0] ck_data,
  output logic              cm_vld,
  output logic [DATA_W-1:0] cm_data,
  output logic              err_flag
);
  logic commit_ok;
  logic mis_seen;
  assign commit_ok = ck_vld & ~ck_mis & ~ck_flt;
  assign mis_seen  = ck_vld & ck_mis;

  always_ff @(posedge clk) begin
    if (rst) begin
      cm_vld   <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      cm_vld   <= commit_ok;
      err_flag <= err_flag | mis_seen;
    end
    cm_data <= ck_data;
  end

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
  // R5
  mis_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
    ck_vld && ck_mis |=> err_flag && !cm_vld);
  // R7
  flt_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    ck_vld && ck_flt |=> !cm_vld);
  // R7
  flt_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    !err_flag && ck_vld && !ck_mis && ck_flt |=> !err_flag);
endmodule

// File: rtl/lockstep_commit_gate.sv
module lockstep_commit_gate
  import lcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_res_a,
  input  logic [DATA_W-1:0] in_res_b,
  input  logic              in_flt,
  input  logic              pa_flt,
  input  logic              eg_flt,
  input  logic              ck_flt,
  output logic              cp_we,
  output logic [DATA_W-1:0] cp_data,
  output logic              cm_vld,
  output logic [DATA_W-1:0] cm_data,
  output logic              err_flag
);
  slot_t             pa_slot;
  slot_t             eg_slot;
  logic [DATA_W-1:0] ckpt_q;
  logic [CODE_W-1:0] eg_code;
  logic              ck_vld;
  logic              ck_mis;
  logic              ck_flt_any;
  logic [DATA_W-1:0] ck_data;

  lcg_ckpt_stage u_pa (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_flt(in_flt),
    .in_a(in_res_a), .in_b(in_res_b), .slot_q(pa_slot), .ckpt_q(ckpt_q)
  );

  lcg_code_stage u_eg (
    .clk(clk), .rst(rst), .slot_i(pa_slot), .ckpt_i(ckpt_q),
    .stage_flt(pa_flt), .slot_q(eg_slot), .code_q(eg_code)
  );

  lcg_check_stage u_ck (
    .clk(clk), .rst(rst), .slot_i(eg_slot), .code_i(eg_code),
    .prev_flt(eg_flt), .here_flt(ck_flt), .ck_vld(ck_vld),
    .ck_mis(ck_mis), .ck_flt_any(ck_flt_any), .ck_data(ck_data)
  );

  lcg_commit_stage u_cm (
    .clk(clk), .rst(rst), .ck_vld(ck_vld), .ck_mis(ck_mis),
    .ck_flt(ck_flt_any), .ck_data(ck_data), .cm_vld(cm_vld),
    .cm_data(cm_data), .err_flag(err_flag)
  );

  assign cp_we   = pa_slot.vld;
  assign cp_data = ckpt_q;

  // R3
  commit_src_chk: assert property (@(posedge clk) disable iff (rst)
    cm_vld |-> $past(ck_vld) && (cm_data == $past(ck_data)));
  // R9
  flow_chk: assert property (@(posedge clk) disable iff (rst)
    cp_we |=> eg_slot.vld);
endmodule

// File: tb/tb_lockstep_commit_gate.sv
module tb_lockstep_commit_gate;
  localparam int SLOTS = 80;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_vld, in_flt, pa_flt, eg_flt, ck_flt;
  logic [63:0] in_res_a, in_res_b;
  logic        cp_we, cm_vld, err_flag;
  logic [63:0] cp_data, cm_data;

  int n_run = 0;
  int n_fail = 0;

  bit          tv  [SLOTS];
  bit          tf0 [SLOTS], tf1 [SLOTS], tf2 [SLOTS], tf3 [SLOTS];
  logic [63:0] ta  [SLOTS], tb  [SLOTS];
  string       tag [SLOTS];

  lockstep_commit_gate dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_res_a(in_res_a),
    .in_res_b(in_res_b), .in_flt(in_flt), .pa_flt(pa_flt),
    .eg_flt(eg_flt), .ck_flt(ck_flt), .cp_we(cp_we), .cp_data(cp_data),
    .cm_vld(cm_vld), .cm_data(cm_data), .err_flag(err_flag)
  );

  always #5 clk = ~clk;

  // Check code restated: XOR together the positions of all set data bits.
  function automatic logic [7:0] ref_code(input logic [63:0] d);
    logic [6:0] acc;
    int pos;
    acc = '0;
    pos = 1;
    for (int j = 0; j < 64; j++) begin
      while ((pos & (pos - 1)) == 0) pos++;
      if (d[j]) acc = acc ^ pos[6:0];
      pos++;
    end
    return {(^d) ^ (^acc), acc};
  endfunction

  function automatic bit exp_commit(input int j);
    return tv[j] && !(tf0[j] || tf1[j] || tf2[j] || tf3[j]) &&
           (ref_code(ta[j]) == ref_code(tb[j]));
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic gen(input int mode, input int cnt);
    for (int i = 0; i < SLOTS; i++) begin
      int r;
      logic [63:0] m;
      tv[i] = (i < cnt) && ((mode == 0) || (mode == 3) || ($urandom % 10 < 7));
      ta[i] = {$urandom, $urandom};
      tb[i] = ta[i];
      tf0[i] = 0; tf1[i] = 0; tf2[i] = 0; tf3[i] = 0;
      tag[i] = (mode == 0) ? "R9" : "R3";
      if (mode == 1) begin
        tf0[i] = ($urandom % 6 == 0); tf1[i] = ($urandom % 6 == 0);
        tf2[i] = ($urandom % 6 == 0); tf3[i] = ($urandom % 6 == 0);
        tag[i] = (tf0[i] || tf1[i] || tf2[i] || tf3[i]) ? "R7" : "R8";
      end else if (mode == 2) begin
        r = $urandom % 4;
        if (r == 1 || r == 2) begin
          m = '0;
          while ($countones(m) < (($urandom % 3) + 1)) m[$urandom % 64] = 1'b1;
          tb[i] = ta[i] ^ m;
          tag[i] = "R6";
        end else if (r == 3) begin
          tb[i] = {$urandom, $urandom};
          tag[i] = "R4";
        end
      end else if (mode == 3) begin
        tag[i] = "R5";
        if (i == 5) tb[i] = ta[i] ^ 64'h0000_0000_0002_0000;
        if (i == 6) begin tb[i] = ta[i] ^ 64'h8000_0000_0000_0001; tag[i] = "R6"; end
        if (i == 7) begin ta[i] = 64'h0; tb[i] = 64'h0000_0000_0000_000F; tag[i] = "R4"; end
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_vld = 0; in_flt = 1; pa_flt = 1; eg_flt = 1; ck_flt = 1;
    repeat (2) @(negedge clk);
    chk(cp_we == 1'b0, "R1", "cp_we in reset", {63'b0, cp_we}, 64'd0);
    chk(cm_vld == 1'b0, "R1", "cm_vld in reset", {63'b0, cm_vld}, 64'd0);
    chk(err_flag == 1'b0, "R1", "err_flag in reset", {63'b0, err_flag}, 64'd0);
    rst = 1'b0;
    in_flt = 0; pa_flt = 0; eg_flt = 0; ck_flt = 0;
  endtask

  task automatic run_phase(input int cnt);
    bit err_exp;
    err_exp = 0;
    for (int k = 0; k < cnt + 5; k++) begin
      @(negedge clk);
      if (k >= 1) begin
        chk(cp_we == tv[k-1], "R2", "cp_we", {63'b0, cp_we}, {63'b0, tv[k-1]});
        if (tv[k-1]) chk(cp_data == ta[k-1], "R2", "cp_data", cp_data, ta[k-1]);
      end
      if (k >= 4) begin
        bit e;
        e = exp_commit(k - 4);
        chk(cm_vld == e, tag[k-4], "cm_vld", {63'b0, cm_vld}, {63'b0, e});
        if (e) chk(cm_data == ta[k-4], tag[k-4], "cm_data", cm_data, ta[k-4]);
        if (tv[k-4] && (ref_code(ta[k-4]) != ref_code(tb[k-4]))) err_exp = 1;
      end
      chk(err_flag == err_exp, "R5", "err_flag", {63'b0, err_flag}, {63'b0, err_exp});
      in_vld   = tv[k];
      in_res_a = ta[k];
      in_res_b = tb[k];
      in_flt   = tf0[k];
      pa_flt   = (k >= 1) ? tf1[k-1] : 1'b0;
      eg_flt   = (k >= 2) ? tf2[k-2] : 1'b0;
      ck_flt   = (k >= 3) ? tf3[k-3] : 1'b0;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1c3a));
    rst = 1'b1;
    in_vld = 0; in_res_a = '0; in_res_b = '0;
    in_flt = 0; pa_flt = 0; eg_flt = 0; ck_flt = 0;
    // R1 R9: back-to-back clean stream
    do_reset(); gen(0, 40); run_phase(40);
    // R3: sparse clean stream
    do_reset(); gen(4, 60); run_phase(60);
    // R7 R8: faults on all stages, including empty slots
    do_reset(); gen(1, 70); run_phase(70);
    // R5 R6: directed flips between clean instructions
    do_reset(); gen(3, 20); run_phase(20);
    // R4 R6: random disagreements
    do_reset(); gen(2, 70); run_phase(70);
    do_reset();
    summary();
    $finish;
  end
endmodule